// File: doc/BRIEF.md
# Shared Tagged Receive Silo

Eight serial receive lines feed one common first-in, first-out store. Every stored word carries the line that produced it, and it holds either a received character with its error flags or a carrier-change notice for that line. A processor drains the store by reading one bus address again and again. Each read returns the oldest word and removes it. The top bit of the word marks it valid, so the reader stops at the first non-negative value.

Writing to that same address does not touch the stored words. The write loads a threshold that decides when the receive interrupt rises. Several lines can offer input in one cycle. A per-line holding stage keeps each offer until the single write port of the store can take it.

Top module: `rx_silo_hub`

## Requirements
- R1: A valid read word is laid out as: bit 15 valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bit 11 carrier-change flag, bits 10:8 line number, bits 7:0 character.
- R2: A read while the store is empty returns 16'h0000 (bit 15 clear) and changes nothing.
- R3: A read of a non-empty store returns the oldest word and removes it, so words leave in the order they were stored.
- R4: A carrier-change strobe on a line whose modem-event enable is set stores a word with bit 11 set, that line's number in bits 10:8 and character 8'h00.
- R5: A character strobe on a line whose receive enable is clear is discarded. A carrier-change strobe on a line whose modem-event enable is clear is discarded.
- R6: At most one word is stored per cycle. The lowest-numbered line with held input goes first, and the others stay held. Within one line, a held carrier-change word goes before a held character.
- R7: The store holds 64 words. An input granted while the store is full and not being read in that cycle is dropped, and the next word that is stored has bit 14 set.
- R8: A bus write loads a threshold from bits 6:0 of the write data and leaves the stored words and the read data unchanged.
- R9: With threshold 0, rx_irq is high exactly while the store is non-empty. With threshold N>0, rx_irq is high exactly while at least N words are stored. It is therefore low whenever the store is empty.
- R10: A strobe sampled at one clock edge is held at that edge and, if no other input is ahead of it, is stored at the next edge. It is readable after that second edge.
- R11: After reset the store is empty, nothing is held, rx_irq is low and the threshold is 0.
- R12: A new character on a line whose previous character is still held and is not granted in that cycle replaces it, and the replacement is stored with bit 14 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ln_chr_stb | input | 8 | Per-line received-character strobe |
| ln_chr | input | 64 | Per-line character, line i in bits 8i+7:8i |
| ln_par_err | input | 8 | Per-line parity error, qualified by the strobe |
| ln_frm_err | input | 8 | Per-line framing error, qualified by the strobe |
| ln_dsc_stb | input | 8 | Per-line carrier-change strobe |
| ln_rx_en | input | 8 | Per-line receive enable |
| ln_mdm_ie | input | 8 | Per-line modem-event enable |
| bus_rd | input | 1 | Read of the receive buffer address (pops) |
| bus_wr | input | 1 | Write to the receive buffer address (threshold) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Head word with valid flag in bit 15 |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
Three events can land in one cycle: a read that pops the head, a grant that pushes a held entry, and a new strobe on a line whose previous entry is still waiting. The bench provokes all of them on purpose. It reads a full store in the same cycle that a grant arrives, strobes a line with both event kinds at once, and runs long stretches of random strobes and reads across all eight lines. A behavioural queue model in the bench predicts the read word and rx_irq for every cycle, and the actual values are compared against it each cycle. Pointed checks then confirm exact words in the full-store and drop sequence.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int TAG_W = 3;
  localparam int CHR_W = 8;

  // Stored word without the valid flag; field order fixes the bus layout.
  typedef struct packed {
    logic             ovr;
    logic             frm;
    logic             par;
    logic             dsc;
    logic [TAG_W-1:0] line;
    logic [CHR_W-1:0] chr;
  } rxs_entry_t;

  function automatic logic [15:0] rxs_word(input logic vld, input rxs_entry_t e);
    return vld ? {1'b1, e} : 16'h0000;
  endfunction

  function automatic logic rxs_irq_due(input int unsigned fill, input int unsigned thr);
    return (thr == 0) ? (fill != 0) : (fill >= thr);
  endfunction
endpackage

// File: rtl/rxs_line_hold.sv
module rxs_line_hold
  import rxs_pkg::*;
#(
  parameter logic [TAG_W-1:0] LINE = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chr_stb,
  input  logic [CHR_W-1:0] chr,
  input  logic             par_err,
  input  logic             frm_err,
  input  logic             dsc_stb,
  input  logic             rx_en,
  input  logic             mdm_ie,
  input  logic             take,
  output logic             req,
  output rxs_entry_t       entry
);
  logic             dsc_held, chr_held, chr_lost, chr_par, chr_frm;
  logic [CHR_W-1:0] chr_q;
  logic             take_dsc, take_chr, acc_chr, acc_dsc;

  assign take_dsc = take & dsc_held;
  assign take_chr = take & ~dsc_held & chr_held;
  assign acc_chr  = chr_stb & rx_en;
  assign acc_dsc  = dsc_stb & mdm_ie;
  assign req      = dsc_held | chr_held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dsc_held <= 1'b0;
      chr_held <= 1'b0;
      chr_lost <= 1'b0;
      chr_par  <= 1'b0;
      chr_frm  <= 1'b0;
      chr_q    <= '0;
    end else begin
      if (acc_dsc)       dsc_held <= 1'b1;
      else if (take_dsc) dsc_held <= 1'b0;
      if (acc_chr) begin
        chr_held <= 1'b1;
        chr_q    <= chr;
        chr_par  <= par_err;
        chr_frm  <= frm_err;
        chr_lost <= chr_held & ~take_chr;
      end else if (take_chr) begin
        chr_held <= 1'b0;
      end
    end
  end

  always_comb begin
    if (dsc_held)
      entry = '{ovr: 1'b0, frm: 1'b0, par: 1'b0, dsc: 1'b1, line: LINE, chr: '0};
    else
      entry = '{ovr: chr_lost, frm: chr_frm, par: chr_par, dsc: 1'b0, line: LINE, chr: chr_q};
  end
endmodule

// File: rtl/rxs_prio_pick.sv
module rxs_prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic found;
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 15,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] occ,
  output logic          push_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign do_pop  = pop & (occ != '0);
  assign push_ok = (occ != CW'(DEPTH)) | do_pop;
  assign do_push = push & push_ok;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + AW'(1);
      unique case ({do_push, do_pop})
        2'b10:   occ <= occ + CW'(1);
        2'b01:   occ <= occ - CW'(1);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/rx_silo_hub.sv
module rx_silo_hub
  import rxs_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DEPTH     = 64,
  localparam int CW       = $clog2(DEPTH) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_LINES-1:0]       ln_chr_stb,
  input  logic [NUM_LINES*CHR_W-1:0] ln_chr,
  input  logic [NUM_LINES-1:0]       ln_par_err,
  input  logic [NUM_LINES-1:0]       ln_frm_err,
  input  logic [NUM_LINES-1:0]       ln_dsc_stb,
  input  logic [NUM_LINES-1:0]       ln_rx_en,
  input  logic [NUM_LINES-1:0]       ln_mdm_ie,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [15:0]                bus_wdata,
  output logic [15:0]                bus_rdata,
  output logic                       rx_irq
);
  logic [NUM_LINES-1:0] line_req, line_gnt;
  rxs_entry_t           ent [NUM_LINES];
  rxs_entry_t           sel_ent, push_word, head;
  logic [CW-1:0]        occ, silo_thr;
  logic                 push_evt, push_ok, drop_evt, ovr_pend;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    rxs_line_hold #(.LINE(TAG_W'(i))) u_hold (
      .clk(clk), .rst_n(rst_n),
      .chr_stb(ln_chr_stb[i]), .chr(ln_chr[i*CHR_W +: CHR_W]),
      .par_err(ln_par_err[i]), .frm_err(ln_frm_err[i]),
      .dsc_stb(ln_dsc_stb[i]), .rx_en(ln_rx_en[i]), .mdm_ie(ln_mdm_ie[i]),
      .take(line_gnt[i]), .req(line_req[i]), .entry(ent[i])
    );
  end

  rxs_prio_pick #(.N(NUM_LINES)) u_pick (.req(line_req), .gnt(line_gnt));

  always_comb begin
    sel_ent = '0;
    for (int i = 0; i < NUM_LINES; i++)
      if (line_gnt[i]) sel_ent = ent[i];
    push_word     = sel_ent;
    push_word.ovr = sel_ent.ovr | ovr_pend;
  end

  assign push_evt = |line_gnt;
  assign drop_evt = push_evt & ~push_ok;

  rxs_fifo #(.DEPTH(DEPTH), .W($bits(rxs_entry_t))) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push_evt), .din(push_word),
    .pop(bus_rd), .dout(head),
    .occ(occ), .push_ok(push_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovr_pend <= 1'b0;
      silo_thr <= '0;
    end else begin
      if (drop_evt)      ovr_pend <= 1'b1;
      else if (push_evt) ovr_pend <= 1'b0;
      if (bus_wr) silo_thr <= bus_wdata[CW-1:0];
    end
  end

  assign bus_rdata = rxs_word(occ != '0, head);
  assign rx_irq    = rxs_irq_due(32'(occ), 32'(silo_thr));
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk #(
  parameter int N     = 8,
  parameter int DEPTH = 64,
  parameter int CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic [CW-1:0] occ,
  input logic [N-1:0]  line_req,
  input logic [N-1:0]  line_gnt,
  input logic          rx_irq
);
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  a_r7_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && occ == CW'(DEPTH)) |=> occ == CW'(DEPTH));

  a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(line_gnt));

  a_r6_grant_when_held: assert property (@(posedge clk) disable iff (!rst_n)
    (line_req != '0) |-> (line_gnt != '0));

  a_r3_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && occ != '0 && line_gnt == '0) |=> occ == $past(occ) - CW'(1));

  a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && line_gnt != '0 && occ < CW'(DEPTH)) |=> occ == $past(occ) + CW'(1));

  a_r9_irq_quiet_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !rx_irq);
endmodule

bind rx_silo_hub rxs_chk #(.N(NUM_LINES), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .occ(occ),
  .line_req(line_req), .line_gnt(line_gnt), .rx_irq(rx_irq)
);

// File: tb/sim_rx_silo_hub.sv
`timescale 1ns/1ps
module sim_rx_silo_hub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  s_cv = '0, s_pe = '0, s_fe = '0, s_ev = '0;
  logic [7:0]  s_rxen = 8'hFF, s_mie = 8'hFF;
  logic [63:0] s_ch = '0;
  logic        s_rd = 1'b0, s_wr = 1'b0;
  logic [15:0] s_wd = '0;
  logic [15:0] bus_rdata;
  logic        rx_irq;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rx_silo_hub u0 (
    .clk(clk), .rst_n(rst_n), .ln_chr_stb(s_cv), .ln_chr(s_ch),
    .ln_par_err(s_pe), .ln_frm_err(s_fe), .ln_dsc_stb(s_ev),
    .ln_rx_en(s_rxen), .ln_mdm_ie(s_mie), .bus_rd(s_rd), .bus_wr(s_wr),
    .bus_wdata(s_wd), .bus_rdata(bus_rdata), .rx_irq(rx_irq)
  );

  // behavioural reference
  bit [14:0] q[$];
  bit        pd[8], pc[8], pl[8], ppe[8], pfe[8];
  bit [7:0]  pch[8];
  bit        ovp;
  int        thr;

  function automatic void check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endfunction

  function automatic void m_reset();
    q.delete();
    for (int i = 0; i < 8; i++) begin pd[i] = 0; pc[i] = 0; pl[i] = 0; end
    ovp = 0; thr = 0;
  endfunction

  function automatic void m_compare();
    bit [15:0] er;
    bit ei;
    er = (q.size() > 0) ? {1'b1, q[0]} : 16'h0000;
    ei = (thr == 0) ? (q.size() > 0) : (q.size() >= thr);
    check(bus_rdata === er, "R3 model rdata", bus_rdata, er);
    check(rx_irq === ei, "R9 model irq", rx_irq, ei);
  endfunction

  function automatic void m_update();
    int g = -1;
    bit ok, gd;
    bit [14:0] w;
    for (int i = 0; i < 8; i++) if (g < 0 && (pd[i] || pc[i])) g = i;
    ok = (q.size() < 64) || (s_rd && q.size() > 0);
    if (s_rd && q.size() > 0) void'(q.pop_front());
    if (g >= 0) begin
      gd = pd[g];
      w = gd ? {4'b0001, 3'(g), 8'h00} : {pl[g], pfe[g], ppe[g], 1'b0, 3'(g), pch[g]};
      if (ok) begin w[14] = w[14] | ovp; q.push_back(w); ovp = 0; end
      else ovp = 1;
      if (gd) pd[g] = 0; else pc[g] = 0;
    end
    for (int i = 0; i < 8; i++) begin
      if (s_ev[i] && s_mie[i]) pd[i] = 1;
      if (s_cv[i] && s_rxen[i]) begin
        pl[i] = pc[i]; pc[i] = 1; pch[i] = s_ch[i*8 +: 8];
        ppe[i] = s_pe[i]; pfe[i] = s_fe[i];
      end
    end
    if (s_wr) thr = int'(s_wd[6:0]);
  endfunction

  // called at negedge+1; returns at next negedge+1
  task automatic step();
    m_compare();
    m_update();
    @(posedge clk);
    @(negedge clk);
    #1;
    s_cv = '0; s_ev = '0; s_pe = '0; s_fe = '0; s_rd = 1'b0; s_wr = 1'b0;
  endtask

  task automatic put_chr(int ln, bit [7:0] c);
    s_cv[ln] = 1'b1; s_ch[ln*8 +: 8] = c;
  endtask

  task automatic read_expect(bit [15:0] exp, string req);
    check(bus_rdata === exp, req, bus_rdata, exp);
    s_rd = 1'b1;
    step();
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    #1;
    // R11 reset state
    check(bus_rdata === 16'h0, "R11 reset rdata", bus_rdata, 0);
    check(rx_irq === 1'b0, "R11 reset irq", rx_irq, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R2 empty read
    s_rd = 1'b1; check(bus_rdata === 16'h0, "R2 empty read", bus_rdata, 0);
    step();
    check(bus_rdata === 16'h0, "R2 still empty", bus_rdata, 0);

    // R10 latency and R1 layout (parity)
    put_chr(3, 8'h41); s_pe[3] = 1'b1; step();
    check(bus_rdata === 16'h0, "R10 not yet stored", bus_rdata, 0);
    step();
    read_expect(16'h9341, "R1 R10 parity word");
    // R1 framing flag
    put_chr(1, 8'h0D); s_fe[1] = 1'b1; step(); step();
    read_expect(16'hA10D, "R1 framing word");

    // R4 carrier change
    s_ev[4] = 1'b1; step(); step();
    read_expect(16'h8C00, "R4 carrier word");

    // R5 gated inputs
    s_mie[2] = 1'b0; s_rxen[5] = 1'b0;
    s_ev[2] = 1'b1; put_chr(5, 8'h99); step(); step(); step();
    check(bus_rdata === 16'h0, "R5 gated inputs discarded", bus_rdata, 0);
    s_mie = 8'hFF; s_rxen = 8'hFF;

    // R6 lowest line first
    put_chr(5, 8'h55); put_chr(2, 8'h22); put_chr(7, 8'h77); step();
    step(); step(); step();
    read_expect(16'h8222, "R6 first line 2");
    read_expect(16'h8555, "R6 then line 5");
    read_expect(16'h8777, "R6 then line 7");
    // R6 carrier before character on one line
    s_ev[6] = 1'b1; put_chr(6, 8'h11); step(); step();
    read_expect(16'h8E00, "R6 carrier first");
    read_expect(16'h8611, "R6 char second");

    // R12 replaced held character: lines 0 and 1 compete, line 1 refreshed
    put_chr(0, 8'h01); put_chr(1, 8'h02); step();
    put_chr(1, 8'h03); step();
    step();
    read_expect(16'h8001, "R12 line 0 first");
    read_expect(16'hC103, "R12 replaced char carries overrun");

    // R8 / R9 threshold
    s_wr = 1'b1; s_wd = 16'h0003; step();
    put_chr(0, 8'hA0); put_chr(1, 8'hA1); step(); step(); step();
    check(rx_irq === 1'b0, "R9 below threshold", rx_irq, 0);
    put_chr(2, 8'hA2); step(); step();
    check(rx_irq === 1'b1, "R9 at threshold", rx_irq, 1);
    s_wr = 1'b1; s_wd = 16'hFFFF; step();
    check(bus_rdata === 16'h80A0, "R8 write keeps head", bus_rdata, 16'h80A0);
    check(rx_irq === 1'b0, "R9 high threshold", rx_irq, 0);
    s_wr = 1'b1; s_wd = 16'h0000; step();
    check(rx_irq === 1'b1, "R9 zero threshold nonempty", rx_irq, 1);
    read_expect(16'h80A0, "R8 contents kept");
    read_expect(16'h81A1, "R3 order");
    read_expect(16'h82A2, "R3 order");
    check(rx_irq === 1'b0, "R9 empty clears irq", rx_irq, 0);

    // R7 full store and drop
    for (int k = 0; k < 66; k++) begin put_chr(0, 8'(k)); step(); end
    step();
    read_expect(16'h8000, "R7 oldest kept");
    put_chr(1, 8'h55); step(); step();
    for (int k = 1; k < 64; k++) read_expect({8'h80, 8'(k)}, "R7 kept chars");
    read_expect(16'hC155, "R7 overrun on next word");
    check(bus_rdata === 16'h0, "R7 drained", bus_rdata, 0);

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      s_cv = 8'($urandom) & 8'($urandom);
      s_ch = {$urandom, $urandom};
      s_pe = 8'($urandom); s_fe = 8'($urandom);
      s_ev = 8'($urandom) & 8'($urandom) & 8'($urandom);
      s_rxen = 8'($urandom) | 8'h81; s_mie = 8'($urandom) | 8'h10;
      s_rd = (n % 600 < 300) ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      s_wr = ($urandom % 50 == 0); s_wd = 16'($urandom % 70);
      step();
    end
    s_rxen = 8'hFF; s_mie = 8'hFF;
    for (int n = 0; n < 80; n++) begin s_rd = 1'b1; step(); end
    check(bus_rdata === 16'h0, "R3 final drain", bus_rdata, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule